// File: doc/BRIEF.md
# Two-Register Stack Execute Datapath

This block is the execute stage of a stack machine. The top of stack is held in one register and the element under it in a second register. Every deeper element lives in an on-chip stack RAM. Three pointers index that RAM: a stack pointer, a local-frame base pointer and an indirect address pointer.

Each cycle the block takes one 8-bit instruction that is already decoded and has no operand field. It may also take a 32-bit immediate word from the fetch side. From these it does ALU and shift work, pushes and pops, frame-relative and absolute RAM accesses, indirect accesses and pointer loads. It spills to or refills from the RAM on every push or pop.

The block drives a registered zero flag for a separate branch unit. Fetch, branching, multiplication and external memory are handled elsewhere.

Top module: `tos_stack_dp`

## Requirements
- R1: While reset is low and right after it, tos and nos are 0, sp is 128, vp is 0 and zero is 0.
- R2: Opcode 0x00 (pop) moves nos into tos, loads nos from stack[sp] and decrements sp.
- R3: Opcodes 0x01..0x05 compute AND, OR, XOR, add (tos+nos) and subtract (nos−tos). The result goes to tos, and the operation then pops once as in R2 (nos from stack[sp], sp−1).
- R4: Opcodes 0x1C, 0x1D and 0x1E shift nos by tos[4:0]: 0x1C is a logical right shift, 0x1D a left shift and 0x1E an arithmetic right shift. The result goes to tos and the operation pops as in R2.
- R5: Every push writes the old nos to stack[sp+1], moves the old tos into nos, places the pushed value in tos and increments sp. All RAM indices wrap modulo 256.
- R6: The push sources are as follows. 101nnnnn pushes stack[n]. 110nnnnn pushes stack[32+n]. 0xF2 pushes imm. 0xF0 pushes sp, zero-extended and taken before the increment. 0xF1 pushes vp.
- R7: 001nnnnn writes tos to stack[n] and pops as in R2.
- R8: 0x18 loads vp from tos[7:0] with a pop. 000100nn writes tos to stack[vp+n] with a pop. 111010nn pushes stack[vp+n].
- R9: 0x1A loads the indirect pointer from tos[7:0] with a pop. 0x15 writes tos to stack[ptr] with a pop, and 0xED pushes stack[ptr]. An indirect access uses the pointer as it stood two instructions earlier, so the instruction right after 0x1A still sees the old pointer.
- R10: 0x1B loads sp from tos[7:0] with no decrement. It also moves nos into tos and loads nos from stack[old sp].
- R11: 0xF8 (duplicate) copies tos into nos, writes the old nos to stack[sp+1] and increments sp. tos stays unchanged.
- R12: zero is 1 in a cycle exactly when tos was 0 in the previous cycle.
- R13: Opcode 0x80 (nop) and every opcode not listed above leave tos, nos, sp, vp, the pointers and the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 8 | Decoded instruction for this cycle |
| imm | input | 32 | Immediate word pushed by opcode 0xF2 |
| tos | output | 32 | Top-of-stack register |
| nos | output | 32 | Next-on-stack register |
| sp | output | 8 | Stack pointer |
| vp | output | 8 | Local-frame base pointer |
| zero | output | 1 | Registered zero flag of the previous tos |

## Verification
The binary ALU operations run on operands where AND, OR and XOR give distinct results. The subtract uses a negative top operand, which shows whether the operand order is swapped. The shifts use a negative operand with an amount above 31, which separates the arithmetic shift from the logical one and confirms that only five bits of the amount are used. The indirect pointer is written and then used by the very next instruction and by the one after it, which tells a one-cycle delay apart from none. A push of sp followed by a load of sp must put the whole stack back exactly, which checks the spill address and the refill address against each other.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
    localparam int OPC_W     = 8;
    localparam int FIELD_W   = 5;
    localparam int CONST_OFS = 1 << FIELD_W;

    typedef enum logic [3:0] {
        C_NOP, C_POP, C_ALU, C_STORE, C_STVP, C_STAR, C_STSP,
        C_PUSH_RAM, C_PUSH_SP, C_PUSH_VP, C_PUSH_IMM, C_DUP
    } cls_e;

    typedef enum logic [2:0] {
        FN_AND, FN_OR, FN_XOR, FN_ADD, FN_SUB, FN_USHR, FN_SHL, FN_SHR
    } alufn_e;

    typedef enum logic [1:0] {
        BASE_ZERO, BASE_VP, BASE_PTR
    } base_e;
endpackage

// File: rtl/tsd_decode.sv
module tsd_decode
    import tsd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [OPC_W-1:0]  op,
    output cls_e              cls,
    output alufn_e            fn,
    output base_e             base,
    output logic [ADDR_W-1:0] ofs
);
    always_comb begin
        cls  = C_NOP;
        fn   = FN_ADD;
        base = BASE_ZERO;
        ofs  = '0;
        casez (op)
            8'b00000000: cls = C_POP;
            8'b00000001: begin cls = C_ALU; fn = FN_AND; end
            8'b00000010: begin cls = C_ALU; fn = FN_OR;  end
            8'b00000011: begin cls = C_ALU; fn = FN_XOR; end
            8'b00000100: begin cls = C_ALU; fn = FN_ADD; end
            8'b00000101: begin cls = C_ALU; fn = FN_SUB; end
            8'b00011100: begin cls = C_ALU; fn = FN_USHR; end
            8'b00011101: begin cls = C_ALU; fn = FN_SHL;  end
            8'b00011110: begin cls = C_ALU; fn = FN_SHR;  end
            8'b000100??: begin cls = C_STORE; base = BASE_VP; ofs = ADDR_W'(op[1:0]); end
            8'b00010101: begin cls = C_STORE; base = BASE_PTR; end
            8'b00011000: cls = C_STVP;
            8'b00011010: cls = C_STAR;
            8'b00011011: cls = C_STSP;
            8'b001?????: begin cls = C_STORE; ofs = ADDR_W'(op[FIELD_W-1:0]); end
            8'b101?????: begin cls = C_PUSH_RAM; ofs = ADDR_W'(op[FIELD_W-1:0]); end
            8'b110?????: begin
                cls = C_PUSH_RAM;
                ofs = ADDR_W'(op[FIELD_W-1:0]) + ADDR_W'(CONST_OFS);
            end
            8'b111010??: begin cls = C_PUSH_RAM; base = BASE_VP; ofs = ADDR_W'(op[1:0]); end
            8'b11101101: begin cls = C_PUSH_RAM; base = BASE_PTR; end
            8'b11110000: cls = C_PUSH_SP;
            8'b11110001: cls = C_PUSH_VP;
            8'b11110010: cls = C_PUSH_IMM;
            8'b11111000: cls = C_DUP;
            default:     cls = C_NOP;
        endcase
    end
endmodule

// File: rtl/tsd_alu.sv
module tsd_alu
    import tsd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alufn_e            fn,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] res
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] amt;
    assign amt = top[SH_W-1:0];

    always_comb begin
        unique case (fn)
            FN_AND:  res = top & nxt;
            FN_OR:   res = top | nxt;
            FN_XOR:  res = top ^ nxt;
            FN_ADD:  res = top + nxt;
            FN_SUB:  res = nxt - top;
            FN_USHR: res = nxt >> amt;
            FN_SHL:  res = nxt << amt;
            FN_SHR:  res = DATA_W'($signed(nxt) >>> amt);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/tsd_ram.sv
module tsd_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tos_stack_dp.sv
module tos_stack_dp
    import tsd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SP_RESET = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  op,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] tos,
    output logic [DATA_W-1:0] nos,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] vp,
    output logic              zero
);
    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] vp;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] ptr_use;
        logic              zf;
    } dp_state_t;

    dp_state_t st_q, st_d;

    cls_e              cls;
    alufn_e            fn;
    base_e             base;
    logic [ADDR_W-1:0] ofs;
    logic [DATA_W-1:0] alu_res;
    logic [ADDR_W-1:0] ram_addr;
    logic [ADDR_W-1:0] rd_addr_d;
    logic [DATA_W-1:0] rd_data;
    logic              we_d;
    logic [ADDR_W-1:0] waddr_d;
    logic [DATA_W-1:0] wdata_d;

    tsd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .op(op), .cls(cls), .fn(fn), .base(base), .ofs(ofs)
    );

    tsd_alu #(.DATA_W(DATA_W)) u_alu (
        .fn(fn), .top(st_q.a), .nxt(st_q.b), .res(alu_res)
    );

    tsd_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(we_d), .waddr(waddr_d), .wdata(wdata_d),
        .raddr(rd_addr_d), .rdata(rd_data)
    );

    always_comb begin
        logic [ADDR_W-1:0] base_val;
        logic [DATA_W-1:0] push_val;
        logic              do_push;
        logic              do_pop;

        unique case (base)
            BASE_VP:  base_val = st_q.vp;
            BASE_PTR: base_val = st_q.ptr_use;
            default:  base_val = '0;
        endcase
        ram_addr  = base_val + ofs;
        rd_addr_d = (cls == C_PUSH_RAM) ? ram_addr : st_q.sp;

        st_d         = st_q;
        st_d.ptr_use = st_q.ptr;
        st_d.zf      = (st_q.a == '0);
        we_d         = 1'b0;
        waddr_d      = st_q.sp + ADDR_W'(1);
        wdata_d      = st_q.b;
        push_val     = rd_data;
        do_push      = 1'b0;
        do_pop       = 1'b0;

        case (cls)
            C_POP:   do_pop = 1'b1;
            C_ALU:   do_pop = 1'b1;
            C_STORE: begin
                do_pop  = 1'b1;
                we_d    = 1'b1;
                waddr_d = ram_addr;
                wdata_d = st_q.a;
            end
            C_STVP: begin
                do_pop    = 1'b1;
                st_d.vp   = st_q.a[ADDR_W-1:0];
            end
            C_STAR: begin
                do_pop    = 1'b1;
                st_d.ptr  = st_q.a[ADDR_W-1:0];
            end
            C_STSP: begin
                st_d.a  = st_q.b;
                st_d.b  = rd_data;
                st_d.sp = st_q.a[ADDR_W-1:0];
            end
            C_PUSH_RAM: do_push = 1'b1;
            C_PUSH_SP: begin
                do_push  = 1'b1;
                push_val = DATA_W'(st_q.sp);
            end
            C_PUSH_VP: begin
                do_push  = 1'b1;
                push_val = DATA_W'(st_q.vp);
            end
            C_PUSH_IMM: begin
                do_push  = 1'b1;
                push_val = imm;
            end
            C_DUP: begin
                do_push  = 1'b1;
                push_val = st_q.a;
            end
            default: ;
        endcase

        if (do_pop) begin
            st_d.a  = (cls == C_ALU) ? alu_res : st_q.b;
            st_d.b  = rd_data;
            st_d.sp = st_q.sp - ADDR_W'(1);
        end
        if (do_push) begin
            we_d    = 1'b1;
            st_d.a  = push_val;
            st_d.b  = st_q.a;
            st_d.sp = st_q.sp + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a       <= '0;
            st_q.b       <= '0;
            st_q.sp      <= ADDR_W'(SP_RESET);
            st_q.vp      <= '0;
            st_q.ptr     <= '0;
            st_q.ptr_use <= '0;
            st_q.zf      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos  = st_q.a;
    assign nos  = st_q.b;
    assign sp   = st_q.sp;
    assign vp   = st_q.vp;
    assign zero = st_q.zf;
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    op,
    input logic [DW-1:0] tos,
    input logic [DW-1:0] nos,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] vp,
    input logic          zero
);
    logic is_push;
    assign is_push = (op[7:5] == 3'b101) || (op[7:5] == 3'b110) ||
                     (op[7:2] == 6'b111010) || (op == 8'hED) ||
                     (op == 8'hF0) || (op == 8'hF1) || (op == 8'hF2);

    p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 8'h00) |=> (tos == $past(nos)) && (sp == $past(sp) - AW'(1)));

    p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 8'h04) |=> (tos == $past(tos) + $past(nos)));

    p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_push |=> (nos == $past(tos)) && (sp == $past(sp) + AW'(1)));

    p_stsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 8'h1B) |=> (sp == $past(tos[AW-1:0])) && (tos == $past(nos)));

    p_dup_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 8'hF8) |=> (tos == $past(tos)) && (nos == $past(tos)));

    p_zero_late_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (zero == ($past(tos) == '0)));

    p_nop_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 8'h80) |=> $stable(tos) && $stable(nos) && $stable(sp) && $stable(vp));
endmodule

bind tos_stack_dp tsd_checker #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op(op), .tos(tos), .nos(nos),
    .sp(sp), .vp(vp), .zero(zero)
);

// File: tb/tos_stack_dp_tb.sv
module tos_stack_dp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op = 8'h80;
    logic [31:0] imm = '0;
    logic [31:0] tos, nos;
    logic [7:0]  sp, vp;
    logic        zero;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    tos_stack_dp u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .imm(imm),
        .tos(tos), .nos(nos), .sp(sp), .vp(vp), .zero(zero)
    );

    // behavioural reference
    logic [31:0] mm [256];
    logic [31:0] ma, mb;
    logic [7:0]  msp, mvp, mptr, mptr_old1;
    logic        mz;

    task automatic m_push(input logic [31:0] v);
        mm[msp + 8'd1] = mb;
        mb  = ma;
        ma  = v;
        msp = msp + 8'd1;
    endtask

    task automatic m_pop(input logic [31:0] newa);
        ma  = newa;
        mb  = mm[msp];
        msp = msp - 8'd1;
    endtask

    task automatic m_apply(input logic [7:0] o, input logic [31:0] iv);
        logic [31:0] a0;
        logic [31:0] b0;
        logic [7:0]  pu;
        logic [7:0]  p0;
        a0 = ma;
        b0 = mb;
        pu = mptr_old1;
        p0 = mptr;
        mz = (a0 == 32'd0);
        casez (o)
            8'h00: m_pop(b0);
            8'h01: m_pop(a0 & b0);
            8'h02: m_pop(a0 | b0);
            8'h03: m_pop(a0 ^ b0);
            8'h04: m_pop(a0 + b0);
            8'h05: m_pop(b0 - a0);
            8'h1C: m_pop(b0 >> a0[4:0]);
            8'h1D: m_pop(b0 << a0[4:0]);
            8'h1E: m_pop($signed(b0) >>> a0[4:0]);
            8'b000100??: begin mm[mvp + {6'd0, o[1:0]}] = a0; m_pop(b0); end
            8'h15: begin mm[pu] = a0; m_pop(b0); end
            8'h18: begin mvp = a0[7:0]; m_pop(b0); end
            8'h1A: begin mptr = a0[7:0]; m_pop(b0); end
            8'h1B: begin ma = b0; mb = mm[msp]; msp = a0[7:0]; end
            8'b001?????: begin mm[{3'd0, o[4:0]}] = a0; m_pop(b0); end
            8'b101?????: m_push(mm[{3'd0, o[4:0]}]);
            8'b110?????: m_push(mm[8'd32 + {3'd0, o[4:0]}]);
            8'b111010??: m_push(mm[mvp + {6'd0, o[1:0]}]);
            8'hED: m_push(mm[pu]);
            8'hF0: m_push({24'd0, msp});
            8'hF1: m_push({24'd0, mvp});
            8'hF2: m_push(iv);
            8'hF8: m_push(a0);
            default: ;
        endcase
        mptr_old1 = p0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (tos !== ma || nos !== mb || sp !== msp || vp !== mvp || zero !== mz) begin
            failures++;
            $display("FAIL %s op=%02h actual tos=%08h nos=%08h sp=%0d vp=%0d zero=%0b expected tos=%08h nos=%08h sp=%0d vp=%0d zero=%0b",
                     tag, op, tos, nos, sp, vp, zero, ma, mb, msp, mvp, mz);
        end
    endtask

    task automatic step(input logic [7:0] o, input logic [31:0] iv, input string tag);
        op  = o;
        imm = iv;
        m_apply(o, iv);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 'x;
        ma = '0; mb = '0; msp = 8'd128; mvp = '0; mptr = '0; mptr_old1 = '0; mz = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;

        // fill the stack, R5 spill mechanics and R6 immediate source
        step(8'hF2, 32'h0000_0011, "R6 imm");
        step(8'hF2, 32'h0000_0022, "R5 push");
        step(8'hF2, 32'h0000_0033, "R5 push");
        step(8'hF2, 32'hFFFF_FFF0, "R6 imm");
        step(8'hF2, 32'h0000_0007, "R5 push");
        step(8'hF2, 32'h8000_0000, "R5 push");
        step(8'hF2, 32'h0000_0021, "R5 push");
        step(8'hF2, 32'h0000_F0F0, "R5 push");

        // R3 binary operations
        step(8'hF2, 32'h0000_0FF0, "R5 push");
        step(8'h01, 32'h0, "R3 and");
        step(8'hF2, 32'h0000_0FF0, "R5 push");
        step(8'h02, 32'h0, "R3 or");
        step(8'hF2, 32'h0000_AAAA, "R5 push");
        step(8'h03, 32'h0, "R3 xor");
        step(8'hF2, 32'hFFFF_FFFB, "R5 push");
        step(8'h05, 32'h0, "R3 sub");
        step(8'hF2, 32'h0000_0005, "R5 push");
        step(8'h04, 32'h0, "R3 add");

        // R4 shifts: negative operand, amount 36 -> 4
        step(8'hF2, 32'h8000_0010, "R5 push");
        step(8'hF2, 32'h0000_0024, "R5 push");
        step(8'h1E, 32'h0, "R4 shr");
        step(8'hF2, 32'h8000_0010, "R5 push");
        step(8'hF2, 32'h0000_0024, "R5 push");
        step(8'h1C, 32'h0, "R4 ushr");
        step(8'hF2, 32'h0000_0021, "R5 push");
        step(8'h1D, 32'h0, "R4 shl");

        // R2 pop
        step(8'h00, 32'h0, "R2 pop");
        step(8'h00, 32'h0, "R2 pop");

        // R7 absolute store and R6 reload
        step(8'hF2, 32'h0000_0ABC, "R5 push");
        step(8'h2A, 32'h0, "R7 store n=10");
        step(8'hAA, 32'h0, "R6 push stack[10]");

        // R8 frame-relative access
        step(8'hF2, 32'h0000_0050, "R5 push");
        step(8'h18, 32'h0, "R8 set vp");
        step(8'hF2, 32'h0000_1234, "R5 push");
        step(8'h12, 32'h0, "R8 store vp+2");
        step(8'hEA, 32'h0, "R8 push vp+2");
        step(8'hF1, 32'h0, "R6 push vp");

        // R9 indirect with one-instruction pointer delay
        step(8'hF2, 32'h0000_0028, "R5 push");
        step(8'h1A, 32'h0, "R9 set ptr 40");
        step(8'h80, 32'h0, "R13 nop");
        step(8'hF2, 32'h0000_BEEF, "R5 push");
        step(8'h15, 32'h0, "R9 store indirect");
        step(8'hC8, 32'h0, "R6 push const 32+8");
        step(8'hF2, 32'h0000_0030, "R5 push");
        step(8'h1A, 32'h0, "R9 set ptr 48");
        step(8'h15, 32'h0, "R9 store uses old ptr");
        step(8'hC8, 32'h0, "R9 old ptr target");
        step(8'hF2, 32'h0000_0077, "R5 push");
        step(8'h15, 32'h0, "R9 store uses new ptr");
        step(8'hD0, 32'h0, "R9 new ptr target");
        step(8'hED, 32'h0, "R9 push indirect");

        // R10 sp reload, R6 push sp
        step(8'hF0, 32'h0, "R6 push sp");
        step(8'h1B, 32'h0, "R10 restore sp");
        step(8'hF8, 32'h0, "R11 dup");
        step(8'hF8, 32'h0, "R11 dup");

        // R12 zero flag
        step(8'hF2, 32'h0, "R12 push zero");
        step(8'h80, 32'h0, "R12 zero late");
        step(8'hF2, 32'h0000_0001, "R12 nonzero");
        step(8'h80, 32'h0, "R12 clear");

        // R13 nop and undefined opcodes
        step(8'h06, 32'h0, "R13 undefined 06");
        step(8'h19, 32'h0, "R13 undefined 19");
        step(8'hFF, 32'hDEAD_BEEF, "R13 undefined FF");
        step(8'hCA, 32'h0, "R13 ram untouched");
        step(8'h00, 32'h0, "R2 pop");

        // R10 sp truncated to 8 bits
        step(8'hF2, 32'h0000_0183, "R5 push");
        step(8'h1B, 32'h0, "R10 load sp");
        step(8'hF2, 32'h0000_0044, "R5 push after sp load");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule